// File: doc/BRIEF.md
# Per-Channel Instruction Fetch Watchdog

This block stops one channel program of an interrupt-driven channel processor from running without limit. Each channel start clears a counter of 16-bit instruction words read from code memory. Each fetch strobe adds one to that counter, or two when the fetched instruction is 32 bits wide. When the watchdog is enabled and the count reaches a single threshold shared by every channel, the block raises a one-cycle error pulse.

A channel-end strobe stops the counting. Fetch strobes that arrive between channels have no effect. Enabling the watchdog with a threshold of zero is a configuration mistake. In that case the count comparison is suppressed, and every interrupt request produces an error pulse instead. Instruction decode, channel scheduling and the handling of the error are done by neighbouring logic.

Top module: `fetch_guard`

## Requirements
- R1: A channel-start strobe restarts the count at zero. A fetch presented in the same cycle as the start strobe is added onto that zero, and the new count is visible after the clock edge that samples the start.
- R2: While a channel runs, a fetch strobe with the double-word flag low adds 1 to the count and one with the flag high adds 2. The result is visible after the sampling edge.
- R3: The count saturates at 2^CNT_W-1 and never wraps. A double-word fetch from 2^CNT_W-2 also lands on 2^CNT_W-1.
- R4: When the watchdog is enabled and the threshold is nonzero, the error output is high for exactly one cycle. That cycle follows the first cycle in which the running channel's count is equal to or greater than the threshold.
- R5: After that pulse, no further comparison error occurs until the next channel-start strobe re-arms the check. The count left over from an earlier channel never causes an error in the start cycle of a new channel.
- R6: With the enable input low, the count still advances, and the error output stays low for comparisons and for interrupt requests alike.
- R7: A channel-end strobe stops counting. A fetch in the end cycle is still added. Fetch strobes after the end leave the count unchanged until the next start.
- R8: With the enable input high and a threshold of zero, each cycle with the interrupt-request strobe high gives an error pulse in the next cycle, and the count comparison raises no error. With a nonzero threshold, interrupt requests have no effect on the error output.
- R9: A synchronous active-high reset clears the count, the running state and the armed state, and drives the error output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wd_en | input | 1 | Watchdog enable |
| thr | input | THR_W | Global fetch-word threshold |
| ch_start | input | 1 | Channel-start strobe |
| ch_end | input | 1 | Channel-end strobe |
| fetch | input | 1 | Instruction-fetch strobe |
| fetch_dbl | input | 1 | Fetched instruction is 32 bits (counts as two words) |
| irq | input | 1 | Interrupt-request strobe |
| err_pulse | output | 1 | One-cycle error pulse |
| fetch_count | output | CNT_W | Words fetched by the current or last channel |

## Verification
The bench builds the block with a 4-bit threshold and a 6-bit counter. With this configuration, every nonzero threshold can be swept in both single-word and double-word steps, and the exact pulse cycle is computed as the ceiling of threshold over step. The narrow counter brings saturation within about thirty double-word fetches, so the clamp at 63 and the crossing from 62 are both reached. Directed sequences then cover the leftover saturated count at a new channel start, fetches in and after the end cycle, the zero-threshold interrupt path, and reset during a running channel.

// File: rtl/fgw_pkg.sv
package fgw_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } fgw_phase_e;

   localparam int unsigned FGW_STEP_NARROW = 1;
   localparam int unsigned FGW_STEP_WIDE   = 2;
endpackage

// File: rtl/fgw_fetch_counter.sv
module fgw_fetch_counter
   import fgw_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ch_start,
   input  logic             ch_end,
   input  logic             fetch,
   input  logic             fetch_dbl,
   output logic [CNT_W-1:0] count,
   output logic             running
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int unsigned      SUM_W   = CNT_W + 1;

   fgw_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, base;
   logic [SUM_W-1:0] sum;
   logic [1:0]       step;
   logic             active;

   // words per fetch: one for a 16-bit instruction, two for a 32-bit one
   always_comb begin
      step = 2'd0;
      if (fetch) begin
         step = fetch_dbl ? 2'(FGW_STEP_WIDE) : 2'(FGW_STEP_NARROW);
      end
   end

   assign active = ch_start | (phase_q == PH_RUN);
   assign base   = ch_start ? '0 : cnt_q;
   assign sum    = {1'b0, base} + SUM_W'(step);

   // clamp on carry out instead of wrapping
   always_comb begin
      cnt_d = cnt_q;
      if (active) begin
         cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      end
   end

   always_comb begin
      phase_d = phase_q;
      if (ch_start) begin
         phase_d = PH_RUN;
      end else if (ch_end) begin
         phase_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         phase_q <= PH_IDLE;
      end else begin
         cnt_q   <= cnt_d;
         phase_q <= phase_d;
      end
   end

   assign count   = cnt_q;
   assign running = (phase_q == PH_RUN);

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ch_start && !fetch) |=> (cnt_q == '0)); // R1
   AST_WIDE_STEP: assert property (@(posedge clk) disable iff (rst)
      ((phase_q == PH_RUN) && !ch_start && fetch && fetch_dbl && (cnt_q < CNT_MAX - CNT_W'(1)))
      |=> ((cnt_q - $past(cnt_q)) == CNT_W'(2))); // R2
   AST_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
      (!ch_start) |=> (cnt_q >= $past(cnt_q))); // R3
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((cnt_q == CNT_MAX) && !ch_start) |=> (cnt_q == CNT_MAX)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((phase_q == PH_IDLE) && !ch_start) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/fgw_thresh_cmp.sv
module fgw_thresh_cmp #(
   parameter int unsigned THR_W = 8,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wd_en,
   input  logic [THR_W-1:0] thr,
   input  logic [CNT_W-1:0] count,
   input  logic             running,
   input  logic             ch_start,
   output logic             err
);
   logic [CNT_W-1:0] thr_ext;
   logic             thr_zero, reached, fire;
   logic             armed_q, armed_d, err_q;

   generate
      if (CNT_W == THR_W) begin : g_same_w
         assign thr_ext = thr;
      end else begin : g_pad_w
         assign thr_ext = {{(CNT_W - THR_W){1'b0}}, thr};
      end
   endgenerate

   assign thr_zero = (thr == '0);
   assign reached  = (count >= thr_ext);
   // the start cycle still sees the previous channel's count, so it is masked
   assign fire     = wd_en & armed_q & running & ~ch_start & ~thr_zero & reached;

   always_comb begin
      armed_d = armed_q;
      if (ch_start) begin
         armed_d = 1'b1;
      end else if (fire) begin
         armed_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         armed_q <= armed_d;
         err_q   <= fire;
      end
   end

   assign err = err_q;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      err_q |=> !err_q); // R5
   AST_ERR_AFTER_REACH: assert property (@(posedge clk) disable iff (rst)
      err_q |-> $past(reached && running)); // R4
   AST_ZERO_THR_NO_CMP: assert property (@(posedge clk) disable iff (rst)
      thr_zero |=> !err_q); // R8
endmodule

// File: rtl/fgw_cfg_check.sv
module fgw_cfg_check #(
   parameter int unsigned THR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wd_en,
   input  logic [THR_W-1:0] thr,
   input  logic             irq,
   output logic             err
);
   logic bad_cfg, err_q;

   assign bad_cfg = wd_en & (thr == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         err_q <= 1'b0;
      end else begin
         err_q <= bad_cfg & irq;
      end
   end

   assign err = err_q;

   AST_CFG_IRQ_ONLY: assert property (@(posedge clk) disable iff (rst)
      !irq |=> !err_q); // R8
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
   parameter int unsigned THR_W = 8,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wd_en,
   input  logic [THR_W-1:0] thr,
   input  logic             ch_start,
   input  logic             ch_end,
   input  logic             fetch,
   input  logic             fetch_dbl,
   input  logic             irq,
   output logic             err_pulse,
   output logic [CNT_W-1:0] fetch_count
);
   generate
      if (THR_W < 1) begin : g_bad_thr
         $error("fetch_guard: THR_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("fetch_guard: CNT_W must be at least 2");
      end
      if (CNT_W < THR_W) begin : g_bad_ratio
         $error("fetch_guard: CNT_W must not be narrower than THR_W");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic             running, cmp_err, cfg_err;

   fgw_fetch_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst       (rst),
      .ch_start  (ch_start),
      .ch_end    (ch_end),
      .fetch     (fetch),
      .fetch_dbl (fetch_dbl),
      .count     (count),
      .running   (running)
   );

   fgw_thresh_cmp #(.THR_W(THR_W), .CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .wd_en    (wd_en),
      .thr      (thr),
      .count    (count),
      .running  (running),
      .ch_start (ch_start),
      .err      (cmp_err)
   );

   fgw_cfg_check #(.THR_W(THR_W)) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .wd_en (wd_en),
      .thr   (thr),
      .irq   (irq),
      .err   (cfg_err)
   );

   assign err_pulse   = cmp_err | cfg_err;
   assign fetch_count = count;

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
      !wd_en |=> !err_pulse); // R6
   AST_ZERO_THR_IRQ: assert property (@(posedge clk) disable iff (rst)
      (wd_en && (thr == '0) && irq) |=> err_pulse); // R8
endmodule

// File: tb/fetch_guard_bench.sv
`timescale 1ns/1ps
module fetch_guard_bench;
   localparam int THR_W = 4;
   localparam int CNT_W = 6;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst, wd_en, ch_start, ch_end, fetch, fetch_dbl, irq;
   logic [THR_W-1:0] thr;
   logic             err_pulse;
   logic [CNT_W-1:0] fetch_count;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fetch_guard #(.THR_W(THR_W), .CNT_W(CNT_W)) u_fetch_guard (
      .clk, .rst, .wd_en, .thr, .ch_start, .ch_end,
      .fetch, .fetch_dbl, .irq, .err_pulse, .fetch_count
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   task automatic start_ch();
      ch_start = 1'b1;
      @(negedge clk);
      ch_start = 1'b0;
   endtask

   task automatic end_ch();
      ch_end = 1'b1;
      @(negedge clk);
      ch_end = 1'b0;
   endtask

   initial begin
      rst = 1'b1; wd_en = 1'b0; thr = '0; ch_start = 1'b0; ch_end = 1'b0;
      fetch = 1'b0; fetch_dbl = 1'b0; irq = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 reset count", int'(fetch_count), 0);
      chk("R9 reset err", int'(err_pulse), 0);
      rst = 1'b0;
      @(negedge clk);

      // sweep every nonzero threshold with both step sizes (R1 R2 R4 R5)
      wd_en = 1'b1;
      for (int t = 1; t < (1 << THR_W); t++) begin
         for (int s = 1; s <= 2; s++) begin
            int kf;
            thr = THR_W'(t);
            start_ch();
            chk("R1 start clears", int'(fetch_count), 0);
            chk("R5 no err at start", int'(err_pulse), 0);
            fetch = 1'b1;
            fetch_dbl = (s == 2);
            kf = (t + s - 1) / s;
            for (int k = 1; k <= kf + 3; k++) begin
               @(negedge clk);
               chk("R2 count step", int'(fetch_count), k * s);
               if (k == kf + 1) chk("R4 pulse", int'(err_pulse), 1);
               else chk("R5 single pulse", int'(err_pulse), 0);
            end
            fetch = 1'b0;
            end_ch();
            chk("R5 quiet after end", int'(err_pulse), 0);
         end
      end

      // saturation with the watchdog disabled (R3 R6)
      wd_en = 1'b0; thr = THR_W'(1);
      start_ch();
      fetch = 1'b1; fetch_dbl = 1'b1;
      for (int k = 1; k <= 40; k++) begin
         int e;
         @(negedge clk);
         e = (2 * k > CMAX) ? CMAX : 2 * k;
         chk("R3 saturate", int'(fetch_count), e);
         chk("R6 disabled silent", int'(err_pulse), 0);
      end
      fetch = 1'b0;
      end_ch();

      // leftover saturated count must not fire in a new channel start (R5 R1)
      wd_en = 1'b1; thr = THR_W'(15);
      start_ch();
      chk("R1 clear after saturate", int'(fetch_count), 0);
      chk("R5 stale count no err", int'(err_pulse), 0);
      @(negedge clk);
      chk("R5 stale count no err late", int'(err_pulse), 0);
      end_ch();

      // end strobe stops counting (R7)
      thr = THR_W'(7);
      start_ch();
      fetch = 1'b1; fetch_dbl = 1'b0;
      repeat (5) @(negedge clk);
      chk("R7 pre-end count", int'(fetch_count), 5);
      ch_end = 1'b1;
      @(negedge clk);
      ch_end = 1'b0;
      chk("R7 end-cycle fetch counted", int'(fetch_count), 6);
      for (int k = 0; k < 4; k++) begin
         fetch_dbl = k[0];
         @(negedge clk);
         chk("R7 idle fetch ignored", int'(fetch_count), 6);
         chk("R7 idle no err", int'(err_pulse), 0);
      end
      fetch = 1'b0; fetch_dbl = 1'b0;

      // zero threshold with enable (R8)
      thr = '0;
      start_ch();
      fetch = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         chk("R8 no cmp err at zero thr", int'(err_pulse), 0);
      end
      fetch = 1'b0;
      irq = 1'b1;
      @(negedge clk);
      chk("R8 irq err first", int'(err_pulse), 1);
      @(negedge clk);
      chk("R8 irq err second", int'(err_pulse), 1);
      irq = 1'b0;
      @(negedge clk);
      chk("R8 irq err ends", int'(err_pulse), 0);
      end_ch();
      thr = THR_W'(4);
      irq = 1'b1;
      @(negedge clk);
      chk("R8 irq ignored nonzero thr", int'(err_pulse), 0);
      irq = 1'b0;
      wd_en = 1'b0; thr = '0;
      irq = 1'b1;
      @(negedge clk);
      chk("R6 irq ignored when disabled", int'(err_pulse), 0);
      irq = 1'b0;

      // reset during a running channel (R9)
      wd_en = 1'b1; thr = THR_W'(9);
      start_ch();
      fetch = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 pre-reset count", int'(fetch_count), 3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 mid reset count", int'(fetch_count), 0);
      chk("R9 mid reset err", int'(err_pulse), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R9 not running after reset", int'(fetch_count), 0);
      end
      fetch = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule